// File: doc/BRIEF.md
# Packed SIMD Averaging Unit

This block computes the lane-wise average of two 256-bit source vectors, under the control of a 32-bit instruction word. The word selects four things: the lane width (8, 16, 32 or 64 bits), whether lanes are signed or unsigned, whether the average truncates or rounds, and the destination register index. Every lane is computed on its own. No carry or borrow crosses a lane boundary.

No lane uses a widened sum. Each operand is first halved by a right shift: arithmetic for signed lanes, logical for unsigned lanes. The two halves are added at lane width. A one-bit correction built from the two low operand bits is added to that sum. The correction is the AND of the low bits for the truncating average and the OR of the low bits for the rounding average. Results, the opcode-valid flag and the destination index are registered, so they appear one clock after the inputs. A word outside the averaging opcode group gives a zero result and a low valid flag.

Top module: `simd_avg_unit`

## Requirements
- R1: One clock after the inputs are applied, `op_valid` is 1 exactly when instruction bits [31:20] equal 0111_0100_0110 and the sub-opcode in bits [19:15] lies in 01000..10111. In every other case `op_valid` is 0.
- R2: When `op_valid` is 0, `result` is all zeros.
- R3: One clock after the inputs are applied, `dest_idx` equals instruction bits [4:0], whether or not the opcode is valid.
- R4: Sub-opcode bit 4 = 0 selects the truncating average. Each lane's result is floor((a+b)/2), the exact mathematical value.
- R5: Sub-opcode bit 4 = 1 selects the rounding average. Each lane's result is floor((a+b+1)/2).
- R6: Sub-opcode bit 2 = 0 treats lanes as two's-complement signed values. Bit 2 = 1 treats lanes as unsigned values.
- R7: Sub-opcode bits [1:0] give the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane i occupies bits [i*W+W-1 : i*W], and no lane's result depends on any other lane.
- R8: While `rst_n` is low, `result` is zero, `op_valid` is 0 and `dest_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 32 | Instruction word |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| result | output | 256 | Registered lane-wise average |
| op_valid | output | 1 | Registered flag: the opcode matched the averaging group |
| dest_idx | output | 5 | Registered destination register index |

## Verification
The hardest behaviour to reach from the ports is the lane boundary under extreme values. The sum of two operands would overflow the lane by one bit, and the sign of that lost carry must be recovered correctly: (max,max), (min,min) and (max,min) for signed and unsigned lanes. The stimulus fills every lane with these pairs, for each of the 16 operations.

Mixed random vectors are also applied under every width code. They show that one lane's overflow never leaks into its neighbour. The bench reference computes each lane at a wider width, so it gives an independent check of the shift-and-correct method.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;
   localparam int unsigned INSN_W    = 32;
   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned SUB_W     = 5;
   localparam int unsigned NUM_EW    = 4;
   localparam logic [11:0] AVG_MAJOR = 12'b0111_0100_0110;
   localparam logic [SUB_W-1:0] SUB_LO = 5'b01000;
   localparam logic [SUB_W-1:0] SUB_HI = 5'b10111;

   typedef enum logic [1:0] {
      EW_8  = 2'd0,
      EW_16 = 2'd1,
      EW_32 = 2'd2,
      EW_64 = 2'd3
   } elem_w_e;

   typedef struct packed {
      logic                 hit;
      logic                 rnd;
      logic                 uns;
      elem_w_e              ew;
      logic [REG_IDX_W-1:0] rd;
   } avg_op_t;
endpackage

// File: rtl/avg_decode.sv
module avg_decode
   import simd_avg_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output avg_op_t           op
);
   logic [SUB_W-1:0] sub;
   logic             major_ok;
   logic             sub_ok;

   assign sub      = insn[19:15];
   assign major_ok = (insn[31:20] == AVG_MAJOR);
   assign sub_ok   = (sub >= SUB_LO) && (sub <= SUB_HI);

   always_comb begin
      op.hit = major_ok && sub_ok;
      op.rnd = sub[4];
      op.uns = sub[2];
      op.ew  = elem_w_e'(sub[1:0]);
      op.rd  = insn[REG_IDX_W-1:0];
   end
endmodule

// File: rtl/avg_lane.sv
module avg_lane #(
   parameter int unsigned LW = 8
) (
   input  logic [LW-1:0] a,
   input  logic [LW-1:0] b,
   input  logic          uns,
   input  logic          rnd,
   output logic [LW-1:0] y
);
   if (LW < 2) begin : g_bad_lw
      $error("avg_lane: LW must be at least 2");
   end

   logic          fill_a, fill_b, corr;
   logic [LW-1:0] half_a, half_b;

   assign fill_a = uns ? 1'b0 : a[LW-1];
   assign fill_b = uns ? 1'b0 : b[LW-1];
   assign half_a = {fill_a, a[LW-1:1]};
   assign half_b = {fill_b, b[LW-1:1]};
   assign corr   = rnd ? (a[0] | b[0]) : (a[0] & b[0]);
   assign y      = half_a + half_b + {{(LW-1){1'b0}}, corr};
endmodule

// File: rtl/avg_width_slice.sv
module avg_width_slice #(
   parameter int unsigned VLEN = 256,
   parameter int unsigned LW   = 8
) (
   input  logic [VLEN-1:0] a,
   input  logic [VLEN-1:0] b,
   input  logic            uns,
   input  logic            rnd,
   output logic [VLEN-1:0] y
);
   localparam int unsigned NLANE = VLEN / LW;

   if (VLEN % LW != 0) begin : g_bad_div
      $error("avg_width_slice: VLEN must be a multiple of LW");
   end

   for (genvar li = 0; li < NLANE; li++) begin : g_lane
      avg_lane #(.LW(LW)) u_lane (
         .a   (a[li*LW +: LW]),
         .b   (b[li*LW +: LW]),
         .uns (uns),
         .rnd (rnd),
         .y   (y[li*LW +: LW])
      );
   end
endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
   import simd_avg_pkg::*;
#(
   parameter int unsigned VLEN = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [INSN_W-1:0]    insn,
   input  logic [VLEN-1:0]      src_a,
   input  logic [VLEN-1:0]      src_b,
   output logic [VLEN-1:0]      result,
   output logic                 op_valid,
   output logic [REG_IDX_W-1:0] dest_idx
);
   localparam int unsigned MAX_LW = 8 << (NUM_EW - 1);

   if (VLEN == 0 || (VLEN % MAX_LW) != 0) begin : g_bad_vlen
      $error("simd_avg_unit: VLEN must be a nonzero multiple of the widest lane");
   end

   avg_op_t         op;
   logic [VLEN-1:0] slice_y [NUM_EW];
   logic [VLEN-1:0] sel_y;

   avg_decode u_dec (
      .insn (insn),
      .op   (op)
   );

   for (genvar gw = 0; gw < NUM_EW; gw++) begin : g_width
      avg_width_slice #(.VLEN(VLEN), .LW(8 << gw)) u_slice (
         .a   (src_a),
         .b   (src_b),
         .uns (op.uns),
         .rnd (op.rnd),
         .y   (slice_y[gw])
      );
   end

   always_comb begin
      sel_y = slice_y[op.ew];
      if (!op.hit) sel_y = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         op_valid <= 1'b0;
         dest_idx <= '0;
      end else begin
         result   <= sel_y;
         op_valid <= op.hit;
         dest_idx <= op.rd;
      end
   end
endmodule

// File: rtl/avg_checker.sv
module avg_checker
   import simd_avg_pkg::*;
#(
   parameter int unsigned VLEN = 256
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [INSN_W-1:0]    insn,
   input logic [VLEN-1:0]      src_a,
   input logic [VLEN-1:0]      src_b,
   input logic [VLEN-1:0]      result,
   input logic                 op_valid,
   input logic [REG_IDX_W-1:0] dest_idx
);
   logic [4:0]         sub;
   logic               in_group;
   logic [8:0]         s8_trunc;
   logic [16:0]        s16_round;
   logic signed [64:0] s64_signed;

   assign sub        = insn[19:15];
   assign in_group   = (insn[31:20] == 12'b0111_0100_0110) && (sub >= 5'd8) && (sub <= 5'd23);
   assign s8_trunc   = {1'b0, src_a[7:0]} + {1'b0, src_b[7:0]};
   assign s16_round  = {1'b0, src_a[15:0]} + {1'b0, src_b[15:0]} + 17'd1;
   assign s64_signed = $signed({src_a[63], src_a[63:0]}) + $signed({src_b[63], src_b[63:0]});

   AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      in_group |=> op_valid); // R1
   AST_VALID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_group |=> !op_valid); // R1
   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (result == '0)); // R2
   AST_DEST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dest_idx == $past(insn[4:0]))); // R3
   AST_BYTE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_group && sub == 5'b01100) |=> (result[7:0] == $past(s8_trunc[8:1]))); // R4
   AST_HALF_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_group && sub == 5'b10101) |=> (result[15:0] == $past(s16_round[16:1]))); // R5
   AST_DBL_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_group && sub == 5'b01011) |=> (result[63:0] == $past(s64_signed[64:1]))); // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (!op_valid && result == '0 && dest_idx == '0)); // R8
endmodule

bind simd_avg_unit avg_checker #(.VLEN(VLEN)) u_avg_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .insn     (insn),
   .src_a    (src_a),
   .src_b    (src_b),
   .result   (result),
   .op_valid (op_valid),
   .dest_idx (dest_idx)
);

// File: tb/tb_simd_avg_unit.sv
module tb_simd_avg_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  insn = '0;
   logic [255:0] src_a = '0;
   logic [255:0] src_b = '0;
   logic [255:0] result;
   logic         op_valid;
   logic [4:0]   dest_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   simd_avg_unit dut (
      .clk(clk), .rst_n(rst_n), .insn(insn), .src_a(src_a), .src_b(src_b),
      .result(result), .op_valid(op_valid), .dest_idx(dest_idx)
   );

   function automatic logic [31:0] mk(input logic [11:0] major, input logic [4:0] sub, input logic [4:0] rd);
      return {major, sub, 5'd7, 5'd3, rd};
   endfunction

   function automatic bit ref_valid(input logic [31:0] w);
      int s = int'(w[19:15]);
      return (w[31:20] == 12'b011101000110) && s >= 8 && s <= 23;
   endfunction

   function automatic logic [255:0] ref_avg(input logic [31:0] w, input logic [255:0] a, input logic [255:0] b);
      logic [255:0] res = '0;
      logic [4:0] s = w[19:15];
      int lw, n;
      logic [63:0] mask;
      if (!ref_valid(w)) return '0;
      lw   = 8 << s[1:0];
      n    = 256 / lw;
      mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
      for (int i = 0; i < n; i++) begin
         logic [63:0] ea, eb;
         logic signed [67:0] x, y, z;
         ea = 64'(a >> (i * lw)) & mask;
         eb = 64'(b >> (i * lw)) & mask;
         x = $signed({4'b0, ea});
         y = $signed({4'b0, eb});
         if (!s[2] && ea[lw-1]) x = x - (68'sd1 <<< lw);
         if (!s[2] && eb[lw-1]) y = y - (68'sd1 <<< lw);
         z = (x + y + (s[4] ? 68'sd1 : 68'sd0)) >>> 1;
         res = res | (256'(z[63:0] & mask) << (i * lw));
      end
      return res;
   endfunction

   function automatic logic [255:0] fill(input int lw, input logic [63:0] v);
      logic [255:0] r = '0;
      for (int i = 0; i < 256 / lw; i++) r = r | (256'(v) << (i * lw));
      return r;
   endfunction

   task automatic apply(input logic [31:0] w, input logic [255:0] a, input logic [255:0] b, input string req);
      logic [255:0] exp_r;
      bit exp_v;
      @(negedge clk);
      insn = w; src_a = a; src_b = b;
      exp_r = ref_avg(w, a, b);
      exp_v = ref_valid(w);
      @(negedge clk);
      total++;
      if (result !== exp_r || op_valid !== exp_v || dest_idx !== w[4:0]) begin
         bad++;
         $display("FAIL %s insn=%h result=%h exp=%h valid=%b exp=%b dest=%0d exp=%0d",
                  req, w, result, exp_r, op_valid, exp_v, dest_idx, w[4:0]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] maj = 12'b011101000110;
      // R8: reset state
      repeat (2) @(negedge clk);
      total++;
      if (result !== '0 || op_valid !== 1'b0 || dest_idx !== 5'd0) begin
         bad++;
         $display("FAIL R8 result=%h valid=%b dest=%0d exp 0/0/0", result, op_valid, dest_idx);
      end
      rst_n = 1'b1;

      // R4 R5 R6 R7: extreme pairs for every op
      for (int sub = 8; sub <= 23; sub++) begin
         logic [4:0] s5 = 5'(sub);
         int lw = 8 << s5[1:0];
         logic [63:0] mx, mn;
         string tag = s5[4] ? "R5/R6/R7" : "R4/R6/R7";
         if (s5[2]) begin
            mx = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
            mn = '0;
         end else begin
            mx = (64'd1 << (lw - 1)) - 1;
            mn = 64'd1 << (lw - 1);
         end
         apply(mk(maj, s5, 5'(sub)), fill(lw, mx), fill(lw, mx), tag);
         apply(mk(maj, s5, 5'(sub + 1)), fill(lw, mn), fill(lw, mn), tag);
         apply(mk(maj, s5, 5'(sub + 2)), fill(lw, mx), fill(lw, mn), tag);
         apply(mk(maj, s5, 5'(sub + 3)), fill(lw, 64'd1), fill(lw, 64'd2), tag);
      end

      // R7: mixed random lanes, every op
      for (int k = 0; k < 64; k++) begin
         logic [255:0] ra, rb;
         for (int j = 0; j < 8; j++) begin
            ra[j*32 +: 32] = $urandom;
            rb[j*32 +: 32] = $urandom;
         end
         apply(mk(maj, 5'(8 + (k % 16)), 5'(k)), ra, rb, "R7");
      end

      // R1 R2 R3: words outside the group
      apply(mk(maj, 5'b00111, 5'd9),  fill(8, 64'hff), fill(8, 64'h01), "R1/R2/R3");
      apply(mk(maj, 5'b11000, 5'd30), fill(8, 64'h44), fill(8, 64'h22), "R1/R2/R3");
      apply(mk(12'b011101000111, 5'b01000, 5'd31), fill(16, 64'h1234), fill(16, 64'h4321), "R1/R2/R3");
      apply(32'h0, fill(64, 64'h5), fill(64, 64'h7), "R1/R2/R3");
      // R1 R3: group edges accepted
      apply(mk(maj, 5'b01000, 5'd17), fill(8, 64'h80), fill(8, 64'h7f), "R1/R3");
      apply(mk(maj, 5'b10111, 5'd0),  fill(64, 64'h3), fill(64, 64'h4), "R1/R3");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule